// File: doc/BRIEF.md
# APB Transfer Capture Monitor

A passive observer that sits beside an APB bus with byte strobes, samples every bus signal on the rising clock edge and drives nothing back onto the bus. It cuts the cycle stream into transfers. For each transfer that completes, it publishes one record. The record carries the address, the direction, the data, the strobes, the error flag, the number of wait states, two timestamps and the latency.

Capture is split over two edges. The address-phase fields are taken when the transfer opens. Read data and the error response are taken only on the edge that completes the transfer. Both timestamps come from a free-running cycle counter inside the block. A separate counter tallies every completion edge seen on the bus, so downstream logic can compare the number of records against it. The block behaves the same whether the bus traffic comes from a test agent or from real masters and slaves.

Top module: `apb_xfer_mon`

## Requirements
- R1: A rising edge with `sel_i`=1 and `enable_i`=0 opens a record. On that edge the monitor latches `addr_i` and `write_i`, and latches `wdata_i` and `strb_i` when `write_i`=1. A write record reports this latched write data and these strobes. A read record reports strobes of 0.
- R2: A transfer completes only on an edge with `sel_i`, `enable_i` and `ready_i` all 1 while a record is open. `rec_valid_o` is then 1 for exactly one cycle, the cycle after that edge. No pulse is produced at the opening edge.
- R3: A read record's data is `rdata_i` as sampled on the completion edge. Values on `rdata_i` during the opening cycle or during wait cycles have no effect.
- R4: `rec_err_o` is `slverr_i` as sampled on the completion edge. `slverr_i` on every other cycle has no effect.
- R5: `rec_wait_o` counts the edges of the open record with `sel_i`=1, `enable_i`=1 and `ready_i`=0. A zero-wait transfer reports 0. The count stops at 2^WAIT_W−1 and does not wrap.
- R6: A TS_W-bit cycle counter reads 0 on the first edge after reset is released, rises by one on every edge, and wraps. `rec_t_setup_o` and `rec_t_done_o` are its values on the opening and completion edges. `rec_lat_o` is their difference modulo 2^TS_W, which is the wait count plus one.
- R7: All record fields hold their values between pulses. This holds in particular when the next transfer opens on the same edge that ends the pulse.
- R8: `xfer_cnt_o` rises by one on every edge with `sel_i`, `enable_i` and `ready_i` all 1, including an edge where no record is open. Such an edge emits no record.
- R9: If `sel_i` falls while a record is open and before completion, the record is discarded and no pulse follows.
- R10: While `rst_ni` is 0, all outputs are 0 and the monitor holds no open record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Observed slave select |
| enable_i | input | 1 | Observed access-phase enable |
| write_i | input | 1 | Observed direction, 1 = write |
| addr_i | input | ADDR_W | Observed address |
| wdata_i | input | DATA_W | Observed write data |
| strb_i | input | DATA_W/8 | Observed byte strobes |
| rdata_i | input | DATA_W | Observed read data |
| ready_i | input | 1 | Observed slave ready |
| slverr_i | input | 1 | Observed slave error |
| rec_valid_o | output | 1 | One-cycle record pulse |
| rec_addr_o | output | ADDR_W | Record address |
| rec_write_o | output | 1 | Record direction |
| rec_data_o | output | DATA_W | Write data or read data |
| rec_strb_o | output | DATA_W/8 | Write strobes, 0 on reads |
| rec_err_o | output | 1 | Error response |
| rec_wait_o | output | WAIT_W | Saturating wait-state count |
| rec_t_setup_o | output | TS_W | Timestamp of the opening edge |
| rec_t_done_o | output | TS_W | Timestamp of the completion edge |
| rec_lat_o | output | TS_W | Completion minus opening time |
| xfer_cnt_o | output | CNT_W | Completion-edge counter |

## Verification
Two things can happen on the same clock edge when transfers run back to back: the record publish pulse ends, and the next transfer's address phase is captured into the shadow fields. The bench runs its vector table with no idle cycle between transfers. One cycle after each new transfer opens, it checks that the published fields still carry the previous record and that the pulse has dropped. A second overlap is the completion edge of a transfer whose wait counter has already saturated. A 300-wait read checks that the count reads 255 and that the latency still counts every cycle.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;
  typedef enum logic {
    MON_IDLE   = 1'b0,
    MON_ACCESS = 1'b1
  } mon_state_e;
endpackage

// File: rtl/apb_mon_timebase.sv
module apb_mon_timebase #(
  parameter int TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_o <= '0;
    else         ts_o <= ts_o + TS_W'(1);
  end
endmodule

// File: rtl/apb_mon_seg.sv
module apb_mon_seg
  import apb_mon_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              enable_i,
  input  logic              ready_i,
  output logic              setup_o,
  output logic              done_o,
  output logic              raw_done_o,
  output logic [WAIT_W-1:0] wait_o
);
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

  mon_state_e state_q, state_d;
  logic       wait_cyc;

  assign setup_o    = sel_i & ~enable_i;
  assign raw_done_o = sel_i & enable_i & ready_i;
  assign done_o     = (state_q == MON_ACCESS) & raw_done_o;
  assign wait_cyc   = (state_q == MON_ACCESS) & sel_i & enable_i & ~ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MON_IDLE:   if (setup_o) state_d = MON_ACCESS;
      MON_ACCESS: begin
        if (setup_o)     state_d = MON_ACCESS; // reopen on a fresh setup
        else if (!sel_i) state_d = MON_IDLE;   // aborted, record dropped
        else if (done_o) state_d = MON_IDLE;
      end
      default:    state_d = MON_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_IDLE;
      wait_o  <= '0;
    end else begin
      state_q <= state_d;
      if (setup_o)                          wait_o <= '0;
      else if (wait_cyc && wait_o != WAIT_MAX) wait_o <= wait_o + WAIT_W'(1);
    end
  end
endmodule

// File: rtl/apb_mon_rec.sv
module apb_mon_rec #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 8,
  parameter int TS_W   = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_i,
  input  logic              done_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] strb_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              slverr_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [DATA_W-1:0] data_o,
  output logic [STRB_W-1:0] strb_o,
  output logic              err_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic [TS_W-1:0]   t_setup_o,
  output logic [TS_W-1:0]   t_done_o,
  output logic [TS_W-1:0]   lat_o
);
  // address-phase shadow, kept apart from the published record
  logic [ADDR_W-1:0] sh_addr;
  logic              sh_write;
  logic [DATA_W-1:0] sh_wdata;
  logic [STRB_W-1:0] sh_strb;
  logic [TS_W-1:0]   sh_ts;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_addr  <= '0;
      sh_write <= 1'b0;
      sh_wdata <= '0;
      sh_strb  <= '0;
      sh_ts    <= '0;
    end else if (setup_i) begin
      sh_addr  <= addr_i;
      sh_write <= write_i;
      sh_wdata <= write_i ? wdata_i : '0;
      sh_strb  <= write_i ? strb_i  : '0;
      sh_ts    <= ts_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      addr_o    <= '0;
      write_o   <= 1'b0;
      data_o    <= '0;
      strb_o    <= '0;
      err_o     <= 1'b0;
      wait_o    <= '0;
      t_setup_o <= '0;
      t_done_o  <= '0;
      lat_o     <= '0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        addr_o    <= sh_addr;
        write_o   <= sh_write;
        data_o    <= sh_write ? sh_wdata : rdata_i;
        strb_o    <= sh_strb;
        err_o     <= slverr_i;
        wait_o    <= wait_i;
        t_setup_o <= sh_ts;
        t_done_o  <= ts_i;
        lat_o     <= ts_i - sh_ts;
      end
    end
  end
endmodule

// File: rtl/apb_xfer_mon.sv
module apb_xfer_mon #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 8,
  parameter int TS_W   = 32,
  parameter int CNT_W  = 16,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              enable_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] strb_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ready_i,
  input  logic              slverr_i,
  output logic              rec_valid_o,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic              rec_write_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic [STRB_W-1:0] rec_strb_o,
  output logic              rec_err_o,
  output logic [WAIT_W-1:0] rec_wait_o,
  output logic [TS_W-1:0]   rec_t_setup_o,
  output logic [TS_W-1:0]   rec_t_done_o,
  output logic [TS_W-1:0]   rec_lat_o,
  output logic [CNT_W-1:0]  xfer_cnt_o
);
  logic [TS_W-1:0]   ts;
  logic              setup, done, raw_done;
  logic [WAIT_W-1:0] wait_cnt;

  apb_mon_timebase #(.TS_W(TS_W)) u_tb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ts_o  (ts)
  );

  apb_mon_seg #(.WAIT_W(WAIT_W)) u_seg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .enable_i  (enable_i),
    .ready_i   (ready_i),
    .setup_o   (setup),
    .done_o    (done),
    .raw_done_o(raw_done),
    .wait_o    (wait_cnt)
  );

  apb_mon_rec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .TS_W(TS_W)
  ) u_rec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .setup_i  (setup),
    .done_i   (done),
    .write_i  (write_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .strb_i   (strb_i),
    .rdata_i  (rdata_i),
    .slverr_i (slverr_i),
    .wait_i   (wait_cnt),
    .ts_i     (ts),
    .valid_o  (rec_valid_o),
    .addr_o   (rec_addr_o),
    .write_o  (rec_write_o),
    .data_o   (rec_data_o),
    .strb_o   (rec_strb_o),
    .err_o    (rec_err_o),
    .wait_o   (rec_wait_o),
    .t_setup_o(rec_t_setup_o),
    .t_done_o (rec_t_done_o),
    .lat_o    (rec_lat_o)
  );

  // raw completion-edge tally, independent of record state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       xfer_cnt_o <= '0;
    else if (raw_done) xfer_cnt_o <= xfer_cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/apb_xfer_mon_chk.sv
module apb_xfer_mon_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 8,
  parameter int TS_W   = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              enable_i,
  input logic              ready_i,
  input logic              slverr_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic              rec_valid_o,
  input logic [ADDR_W-1:0] rec_addr_o,
  input logic              rec_write_o,
  input logic [DATA_W-1:0] rec_data_o,
  input logic              rec_err_o,
  input logic [WAIT_W-1:0] rec_wait_o,
  input logic [TS_W-1:0]   rec_lat_o,
  input logic [CNT_W-1:0]  xfer_cnt_o
);
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

  // R2
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o);

  // R2
  pulse_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> $past(sel_i && enable_i && ready_i));

  // R3
  rdata_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_write_o) |-> (rec_data_o == $past(rdata_i)));

  // R4
  err_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_err_o == $past(slverr_i)));

  // R6
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_wait_o != WAIT_MAX) |-> (rec_lat_o == TS_W'(rec_wait_o) + TS_W'(1)));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_valid_o |-> ($stable(rec_addr_o) && $stable(rec_data_o) && $stable(rec_wait_o)));

  // R8
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && enable_i && ready_i) |=> (xfer_cnt_o == $past(xfer_cnt_o) + CNT_W'(1)));

  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && enable_i && ready_i) |=> $stable(xfer_cnt_o));
endmodule

bind apb_xfer_mon apb_xfer_mon_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .TS_W(TS_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .enable_i   (enable_i),
  .ready_i    (ready_i),
  .slverr_i   (slverr_i),
  .rdata_i    (rdata_i),
  .rec_valid_o(rec_valid_o),
  .rec_addr_o (rec_addr_o),
  .rec_write_o(rec_write_o),
  .rec_data_o (rec_data_o),
  .rec_err_o  (rec_err_o),
  .rec_wait_o (rec_wait_o),
  .rec_lat_o  (rec_lat_o),
  .xfer_cnt_o (xfer_cnt_o)
);

// File: tb/tb_apb_xfer_mon.sv
`timescale 1ns/1ps
module tb_apb_xfer_mon;
  localparam int CLK_NS = 20;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic        err;
    logic [8:0]  waits;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 32'h1000_0000, 32'hA5A5_0001, 4'hF, 1'b0, 9'd0},
    '{1'b0, 32'h1000_0004, 32'hCAFE_BABE, 4'h0, 1'b0, 9'd1},
    '{1'b1, 32'h1000_0008, 32'h1234_5678, 4'h3, 1'b1, 9'd2},
    '{1'b0, 32'h1000_000C, 32'hDEAD_BEEF, 4'h0, 1'b1, 9'd0},
    '{1'b0, 32'h2000_0010, 32'h0BAD_F00D, 4'h0, 1'b0, 9'd3},
    '{1'b1, 32'h2000_0014, 32'h5555_AAAA, 4'h8, 1'b0, 9'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, en = 1'b0, wr = 1'b0, rdy = 1'b0, serr = 1'b0;
  logic [31:0] addr = '0, wdata = '0, rdata = '0;
  logic [3:0]  strb = '0;

  logic        rec_valid, rec_write, rec_err;
  logic [31:0] rec_addr, rec_data, rec_t_setup, rec_t_done, rec_lat;
  logic [3:0]  rec_strb;
  logic [7:0]  rec_wait;
  logic [15:0] xfer_cnt;

  int checks = 0, fails = 0, pulses = 0, edge_n = 0;

  always #(CLK_NS/2) clk = ~clk;

  apb_xfer_mon dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .enable_i(en), .write_i(wr),
    .addr_i(addr), .wdata_i(wdata), .strb_i(strb), .rdata_i(rdata),
    .ready_i(rdy), .slverr_i(serr),
    .rec_valid_o(rec_valid), .rec_addr_o(rec_addr), .rec_write_o(rec_write),
    .rec_data_o(rec_data), .rec_strb_o(rec_strb), .rec_err_o(rec_err),
    .rec_wait_o(rec_wait), .rec_t_setup_o(rec_t_setup), .rec_t_done_o(rec_t_done),
    .rec_lat_o(rec_lat), .xfer_cnt_o(xfer_cnt)
  );

  // edge index since reset release = expected timestamp of the next edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;
  end

  always @(posedge clk) begin
    #5;
    if (rec_valid) pulses++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // drives one transfer from setup to completion; returns at the negedge after completion
  task automatic run_xfer(input vec_t v, input int nwait, input bit hold_chk,
                          input logic [31:0] prev_addr);
    int ts_s;
    int exp_w;
    ts_s = edge_n;
    sel = 1'b1; en = 1'b0; wr = v.wr; addr = v.addr;
    wdata = v.wr ? v.data : 32'h0;
    strb = v.strb;
    rdy = 1'b1; serr = 1'b1; rdata = 32'hFFFF_0000;   // noise during setup
    @(negedge clk);
    if (hold_chk) begin
      chk_eq("R7", "pulse dropped at next setup", rec_valid, 0);
      chk_eq("R7", "old addr held", rec_addr, prev_addr);
    end else begin
      chk_eq("R2", "no pulse at setup", rec_valid, 0);
    end
    en = 1'b1; addr = ~v.addr; wdata = ~v.data; strb = ~v.strb;
    for (int i = 0; i < nwait; i++) begin
      rdy = 1'b0; rdata = ~v.data; serr = ~v.err;
      @(negedge clk);
      if (i == 0) chk_eq("R2", "no pulse in wait", rec_valid, 0);
    end
    rdy = 1'b1; rdata = v.wr ? 32'h0F0F_0F0F : v.data; serr = v.err;
    @(negedge clk);
    exp_w = (nwait > 255) ? 255 : nwait;
    chk_eq("R2", "pulse after completion", rec_valid, 1);
    chk_eq("R1", "addr", rec_addr, v.addr);
    chk_eq("R1", "direction", rec_write, v.wr);
    chk_eq(v.wr ? "R1" : "R3", "data", rec_data, v.data);
    chk_eq("R1", "strobes", rec_strb, v.wr ? v.strb : 4'h0);
    chk_eq("R4", "error", rec_err, v.err);
    chk_eq("R5", "wait count", rec_wait, exp_w);
    chk_eq("R6", "setup stamp", rec_t_setup, ts_s);
    chk_eq("R6", "done stamp", rec_t_done, ts_s + 1 + nwait);
    chk_eq("R6", "latency", rec_lat, nwait + 1);
  endtask

  task automatic bus_idle();
    sel = 1'b0; en = 1'b0; rdy = 1'b0; serr = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int p0;
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk_eq("R10", "valid in reset", rec_valid, 0);
    chk_eq("R10", "addr in reset", rec_addr, 0);
    chk_eq("R10", "count in reset", xfer_cnt, 0);
    chk_eq("R10", "latency in reset", rec_lat, 0);
    rst_n = 1'b1;

    // vector table, back to back
    for (int k = 0; k < NVEC; k++)
      run_xfer(VECS[k], int'(VECS[k].waits), k > 0, k > 0 ? VECS[k-1].addr : 32'h0);
    bus_idle();
    @(negedge clk);
    chk_eq("R7", "fields held after pulse", rec_data, VECS[NVEC-1].data);
    chk_eq("R2", "one record per transfer", pulses, NVEC);
    chk_eq("R8", "count after table", xfer_cnt, NVEC);

    // R8: completion with no open record
    p0 = pulses; c0 = xfer_cnt;
    sel = 1'b1; en = 1'b1; rdy = 1'b1;
    @(negedge clk);
    bus_idle();
    @(negedge clk);
    chk_eq("R8", "orphan completion counted", xfer_cnt, c0 + 1);
    chk_eq("R8", "orphan completion no record", pulses, p0);

    // R9: aborted transfer
    p0 = pulses; c0 = xfer_cnt;
    sel = 1'b1; en = 1'b0; wr = 1'b0; addr = 32'h3000_0000;
    @(negedge clk);
    en = 1'b1; rdy = 1'b0;
    @(negedge clk);
    bus_idle();
    repeat (2) @(negedge clk);
    chk_eq("R9", "abort no pulse", pulses, p0);
    chk_eq("R9", "abort no count", xfer_cnt, c0);
    chk_eq("R9", "record unchanged", rec_addr, VECS[NVEC-1].addr);

    // R5: saturating wait count
    run_xfer('{1'b0, 32'h4000_0000, 32'h7777_8888, 4'h0, 1'b1, 9'd0}, 300, 1'b0, 32'h0);
    bus_idle();
    @(negedge clk);

    // R10: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk_eq("R10", "count cleared", xfer_cnt, 0);
    chk_eq("R10", "wait cleared", rec_wait, 0);
    chk_eq("R10", "stamp cleared", rec_t_done, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule